// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block is the configuration space of a legacy plug-and-play peripheral controller, reached from an 8-bit host bus through a pair of byte ports. The port at offset 0 holds an index and the port at offset 1 moves data to or from the register that the index names. The space stays locked after reset. The host opens it by writing a fixed key byte to the index port twice in a row, and closes it by writing an exit byte to the same port.

Once open, the low indices hold chip-wide controls: a logical device selector, a set of per-function power-down bits and an immediate power-down for the whole chip. Indices from 0x30 upward reach a bank of registers that belongs to the device named by the selector. Each bank holds an enable, two 16-bit I/O bases, two interrupt selections and a DMA channel. Every bank drives its own set of outputs, so the peripherals downstream see their settings directly and do not have to decode the ports themselves.

Top module: `sio_cfg_regfile`

## Requirements
- R1: Port offset 0 is the index port and offset 1 is the data port. While the space is open, reading the index port returns the current index. Read data is 0x00 whenever `bus_rd` is low.
- R2: The space opens after two consecutive index-port writes of 0x87. Any other byte written to the index port while locked clears the key progress.
- R3: Writing 0xAA to the index port while open locks the space. The index, all register contents and all outputs are kept.
- R4: While locked, data-port writes change nothing, index-port writes do not change the index, and reads of either port return 0xFF.
- R5: Global index 0x07 holds the device selector. Selector values 0x00–0x0C pick a bank. With any other value, bank writes are ignored and bank reads return 0x00.
- R6: Bank index 0x30 bit 0 drives `dev_active[sel]`. The other bits of that register read as 0.
- R7: Bank indices 0x60/0x61 hold the high and low bytes of `io0_base[16*sel +: 16]`, and 0x62/0x63 do the same for `io1_base`.
- R8: Bank indices 0x70, 0x72 and 0x74 hold the full bytes `irq0`, `irq1` and `dma` of the selected device, each at `[8*sel +: 8]`.
- R9: Global index 0x22 stores only bits 0, 3, 4, 5 and 6 (floppy, parallel port, UART A, UART B, hardware monitor). Bits 1, 2 and 7 read 0 and drive 0 on `pwrdn`.
- R10: Bit 0 of global index 0x23 drives `chip_pd`. Reading the register returns the current state in bit 0 and 0 in all other bits.
- R11: Every index not named in R5–R10 reads 0x00, and writes to it have no effect.
- R12: After a synchronous reset every register is 0, the selector is 0, the index is 0 and the space is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 1 | Port select: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| cfg_open | output | 1 | Configuration space unlocked |
| dev_active | output | NDEV | Enable per logical device |
| io0_base | output | 16*NDEV | First I/O base per device |
| io1_base | output | 16*NDEV | Second I/O base per device |
| irq0 | output | 8*NDEV | First interrupt selection per device |
| irq1 | output | 8*NDEV | Second interrupt selection per device |
| dma | output | 8*NDEV | DMA channel per device |
| pwrdn | output | 8 | Per-function power-down bits |
| chip_pd | output | 1 | Whole-chip power-down |

## Verification
The address decode is exercised by a sweep over every index except the selector and the exit byte. Each register receives a value derived from its own index, so a mis-decoded or aliased register reads back a value that belongs to a different index. A second sweep loads every one of the thirteen banks with values that depend on both the device number and the field. Cross-talk between banks, or a field swapped inside a bank, therefore shows up on the flattened outputs. Key sequences are tried with a broken run (key, other byte, key), with a clean pair, with locked writes to the data port, and with an out-of-range selector. Together these separate a matcher that forgets its progress from one that does not, and a locked port from an open one.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] IDX_SEL    = 8'h07;
  localparam logic [7:0] IDX_PWRDN  = 8'h22;
  localparam logic [7:0] IDX_CHIPPD = 8'h23;
  localparam logic [7:0] IDX_BANK   = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_IO0H   = 8'h60;
  localparam logic [7:0] IDX_IO0L   = 8'h61;
  localparam logic [7:0] IDX_IO1H   = 8'h62;
  localparam logic [7:0] IDX_IO1L   = 8'h63;
  localparam logic [7:0] IDX_IRQ0   = 8'h70;
  localparam logic [7:0] IDX_IRQ1   = 8'h72;
  localparam logic [7:0] IDX_DMA    = 8'h74;
  localparam logic [7:0] PD_MASK    = 8'h79;

  function automatic logic [7:0] pd_keep(input logic [7:0] v);
    return v & PD_MASK;
  endfunction

  function automatic logic [15:0] base16(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic is_bank_idx(input logic [7:0] idx);
    return idx >= IDX_BANK;
  endfunction
endpackage

// File: rtl/sio_port_ctl.sv
module sio_port_ctl #(
  parameter int         KEY_LEN   = 2,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       open,
  output logic [7:0] index,
  output logic       data_we
);
  localparam int CW = $clog2(KEY_LEN + 1);

  logic [CW-1:0] key_cnt;
  logic idx_we, key_hit, key_done, exit_hit;

  assign idx_we   = wr_en && !port_sel;
  assign key_hit  = idx_we && !open && (wdata == KEY_BYTE);
  assign key_done = key_hit && (key_cnt == CW'(KEY_LEN - 1));
  assign exit_hit = idx_we && open && (wdata == EXIT_BYTE);
  assign data_we  = wr_en && port_sel && open;

  always_ff @(posedge clk) begin
    if (rst) begin
      open    <= 1'b0;
      key_cnt <= '0;
      index   <= 8'h00;
    end else begin
      if (key_done) begin
        open    <= 1'b1;
        key_cnt <= '0;
      end else if (idx_we && !open) begin
        key_cnt <= key_hit ? key_cnt + CW'(1) : '0;
      end
      if (exit_hit) open <= 1'b0;
      if (idx_we && open && !exit_hit) index <= wdata;
    end
  end

  // R2: a non-key byte while locked drops all key progress
  assert_key_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel && !open && wdata != KEY_BYTE) |=> (key_cnt == '0 && !open));

  // R3: the exit byte locks and keeps the index
  assert_exit_locks_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel && open && wdata == EXIT_BYTE) |=> (!open && $stable(index)));

  // R4: index frozen while locked
  assert_locked_index_R4: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(index));
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] sel,
  output logic [7:0] pwrdn,
  output logic       chip_pd,
  output logic [7:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 8'h00;
      pwrdn   <= 8'h00;
      chip_pd <= 1'b0;
    end else if (we) begin
      case (idx)
        IDX_SEL:    sel     <= wdata;
        IDX_PWRDN:  pwrdn   <= pd_keep(wdata);
        IDX_CHIPPD: chip_pd <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_SEL:    rdata = sel;
      IDX_PWRDN:  rdata = pwrdn;
      IDX_CHIPPD: rdata = {7'b0, chip_pd};
      default:    rdata = 8'h00;
    endcase
  end

  // R9: reserved power-down bits never set
  assert_pd_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    we |=> ((pwrdn & ~PD_MASK) == 8'h00));

  // R10: chip power-down only moves on a write to its index
  assert_chip_pd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(we && idx == IDX_CHIPPD) |=> $stable(chip_pd));
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] io0,
  output logic [15:0] io1,
  output logic [7:0]  irq0,
  output logic [7:0]  irq1,
  output logic [7:0]  dma,
  output logic [7:0]  rdata
);
  logic [7:0] io0_hi, io0_lo, io1_hi, io1_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      io0_hi <= 8'h00; io0_lo <= 8'h00;
      io1_hi <= 8'h00; io1_lo <= 8'h00;
      irq0   <= 8'h00; irq1   <= 8'h00;
      dma    <= 8'h00;
    end else if (we) begin
      case (idx)
        IDX_ACT:  active <= wdata[0];
        IDX_IO0H: io0_hi <= wdata;
        IDX_IO0L: io0_lo <= wdata;
        IDX_IO1H: io1_hi <= wdata;
        IDX_IO1L: io1_lo <= wdata;
        IDX_IRQ0: irq0   <= wdata;
        IDX_IRQ1: irq1   <= wdata;
        IDX_DMA:  dma    <= wdata;
        default: ;
      endcase
    end
  end

  assign io0 = base16(io0_hi, io0_lo);
  assign io1 = base16(io1_hi, io1_lo);

  always_comb begin
    case (idx)
      IDX_ACT:  rdata = {7'b0, active};
      IDX_IO0H: rdata = io0_hi;
      IDX_IO0L: rdata = io0_lo;
      IDX_IO1H: rdata = io1_hi;
      IDX_IO1L: rdata = io1_lo;
      IDX_IRQ0: rdata = irq0;
      IDX_IRQ1: rdata = irq1;
      IDX_DMA:  rdata = dma;
      default:  rdata = 8'h00;
    endcase
  end

  // R5: an unselected bank holds all of its state
  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(active) && $stable(io0) && $stable(io1)
             && $stable(irq0) && $stable(irq1) && $stable(dma)));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int         NDEV      = 13,
  parameter int         KEY_LEN   = 2,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               cfg_open,
  output logic [NDEV-1:0]    dev_active,
  output logic [16*NDEV-1:0] io0_base,
  output logic [16*NDEV-1:0] io1_base,
  output logic [8*NDEV-1:0]  irq0,
  output logic [8*NDEV-1:0]  irq1,
  output logic [8*NDEV-1:0]  dma,
  output logic [7:0]         pwrdn,
  output logic               chip_pd
);
  localparam int         SW     = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [7:0] NDEV_B = 8'(NDEV);

  logic [7:0] cur_idx, sel, glob_rdata, bank_sel_rdata, open_rdata;
  logic       data_we, sel_ok, glob_we;
  logic [7:0] bank_rdata [NDEV];

  sio_port_ctl #(.KEY_LEN(KEY_LEN), .KEY_BYTE(KEY_BYTE), .EXIT_BYTE(EXIT_BYTE)) u_port (
    .clk(clk), .rst(rst), .port_sel(bus_addr), .wr_en(bus_wr), .wdata(bus_wdata),
    .open(cfg_open), .index(cur_idx), .data_we(data_we)
  );

  assign glob_we = data_we && !is_bank_idx(cur_idx);
  assign sel_ok  = sel < NDEV_B;

  sio_global_regs u_glob (
    .clk(clk), .rst(rst), .we(glob_we), .idx(cur_idx), .wdata(bus_wdata),
    .sel(sel), .pwrdn(pwrdn), .chip_pd(chip_pd), .rdata(glob_rdata)
  );

  for (genvar g = 0; g < NDEV; g++) begin : g_bank
    logic bank_we;
    assign bank_we = data_we && is_bank_idx(cur_idx) && (sel == 8'(g));
    sio_dev_bank u_bank (
      .clk(clk), .rst(rst), .we(bank_we), .idx(cur_idx), .wdata(bus_wdata),
      .active(dev_active[g]),
      .io0(io0_base[16*g +: 16]), .io1(io1_base[16*g +: 16]),
      .irq0(irq0[8*g +: 8]), .irq1(irq1[8*g +: 8]), .dma(dma[8*g +: 8]),
      .rdata(bank_rdata[g])
    );
  end

  assign bank_sel_rdata = sel_ok ? bank_rdata[sel[SW-1:0]] : 8'h00;

  always_comb begin
    if (!bus_addr)                 open_rdata = cur_idx;
    else if (is_bank_idx(cur_idx)) open_rdata = bank_sel_rdata;
    else                           open_rdata = glob_rdata;
  end

  always_comb begin
    if (!bus_rd)        bus_rdata = 8'h00;
    else if (!cfg_open) bus_rdata = 8'hFF;
    else                bus_rdata = open_rdata;
  end

  // R4: locked reads give all ones
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && bus_rd) |-> (bus_rdata == 8'hFF));

  // R4: locked data writes leave every output alone
  assert_locked_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && bus_wr && bus_addr) |=> ($stable(dev_active) && $stable(io0_base)
      && $stable(io1_base) && $stable(irq0) && $stable(irq1) && $stable(dma)
      && $stable(pwrdn) && $stable(chip_pd)));

  // R12: reset leaves the space locked
  assert_reset_locked_R12: assert property (@(posedge clk)
    $past(rst) |-> !cfg_open);
endmodule

// File: tb/tb_sio_cfg_regfile.sv
module tb_sio_cfg_regfile;
  localparam int NDEV = 13;

  logic clk = 0, rst = 1, bus_addr = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic cfg_open, chip_pd;
  logic [NDEV-1:0] dev_active;
  logic [16*NDEV-1:0] io0_base, io1_base;
  logic [8*NDEV-1:0] irq0, irq1, dma;
  logic [7:0] pwrdn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_cfg_regfile dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .io0_base(io0_base), .io1_base(io1_base),
    .irq0(irq0), .irq1(irq1), .dma(dma), .pwrdn(pwrdn), .chip_pd(chip_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic setreg(input logic [7:0] idx, input logic [7:0] v);
    wr(0, idx); wr(1, v);
  endtask

  task automatic unlock();
    wr(0, 8'h87); wr(0, 8'h87);
  endtask

  function automatic logic [7:0] sweep_val(input int idx);
    return 8'(idx) ^ 8'h5C;
  endfunction

  function automatic logic [7:0] sweep_exp(input int idx);
    logic [7:0] v = sweep_val(idx);
    case (idx)
      'h22: return v & 8'h79;
      'h23, 'h30: return v & 8'h01;
      'h60, 'h61, 'h62, 'h63, 'h70, 'h72, 'h74: return v;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dval(input int d, input int k);
    return 8'(d * 16 + k * 7 + 3);
  endfunction

  task automatic check_devs(input string req);
    for (int d = 0; d < NDEV; d++) begin
      chk(req, dev_active[d], (d % 2 == 0) ? 1 : 0);
      chk(req, io0_base[16*d +: 16], {dval(d,0), dval(d,1)});
      chk(req, io1_base[16*d +: 16], {dval(d,2), dval(d,3)});
      chk(req, irq0[8*d +: 8], dval(d,4));
      chk(req, irq1[8*d +: 8], dval(d,5));
      chk(req, dma[8*d +: 8], dval(d,6));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 open", cfg_open, 0);
    chk("R12 active", dev_active, 0);
    chk("R12 io0", io0_base[31:0], 0);
    chk("R12 pwrdn", pwrdn, 0);
    chk("R12 chip_pd", chip_pd, 0);
    rd(1, r); chk("R4 locked data read", r, 8'hFF);
    rd(0, r); chk("R4 locked index read", r, 8'hFF);

    // R4 locked data write ignored, index held
    unlock();
    chk("R2 open after key", cfg_open, 1);
    wr(0, 8'h22);
    wr(0, 8'hAA);
    chk("R3 locked", cfg_open, 0);
    wr(1, 8'hFF);
    chk("R4 pwrdn unchanged", pwrdn, 0);
    unlock();
    rd(0, r); chk("R1 index kept", r, 8'h22);
    rd(1, r); chk("R4 locked write ignored", r, 8'h00);
    @(negedge clk); bus_addr = 1; #1 chk("R1 rd low gives 0", bus_rdata, 0);

    // R2 broken key run
    wr(0, 8'hAA);
    wr(0, 8'h87); wr(0, 8'h12); wr(0, 8'h87);
    chk("R2 broken run stays locked", cfg_open, 0);
    rd(1, r); chk("R2 locked read", r, 8'hFF);
    wr(0, 8'h87);
    chk("R2 second consecutive key opens", cfg_open, 1);

    // R11 R9 R10 R6 index sweep on device 0
    for (int i = 0; i < 256; i++) begin
      if (i == 'h07 || i == 'hAA) continue;
      setreg(8'(i), sweep_val(i));
    end
    for (int i = 0; i < 256; i++) begin
      if (i == 'h07 || i == 'hAA) continue;
      wr(0, 8'(i)); rd(1, r);
      chk("R11 index sweep readback", {24'(i), r}, {24'(i), sweep_exp(i)});
    end
    chk("R9 pwrdn output", pwrdn, sweep_exp('h22));
    chk("R10 chip_pd set", chip_pd, 1);
    chk("R6 active dev0", dev_active[0], sweep_exp('h30));
    chk("R7 io0 dev0", io0_base[15:0], {sweep_val('h60), sweep_val('h61)});
    setreg(8'h23, 8'hFE);
    chk("R10 chip_pd cleared", chip_pd, 0);
    rd(1, r); chk("R10 readback", r, 8'h00);
    setreg(8'h22, 8'hFF);
    chk("R9 reserved bits", pwrdn, 8'h79);

    // R5 R6 R7 R8 all banks
    for (int d = 0; d < NDEV; d++) begin
      setreg(8'h07, 8'(d));
      setreg(8'h30, (d % 2 == 0) ? 8'hF1 : 8'hF0);
      setreg(8'h60, dval(d,0)); setreg(8'h61, dval(d,1));
      setreg(8'h62, dval(d,2)); setreg(8'h63, dval(d,3));
      setreg(8'h70, dval(d,4)); setreg(8'h72, dval(d,5));
      setreg(8'h74, dval(d,6));
    end
    check_devs("R7 R8 banks");
    for (int d = 0; d < NDEV; d++) begin
      setreg(8'h07, 8'(d));
      wr(0, 8'h30); rd(1, r); chk("R6 active readback", r, (d % 2 == 0) ? 1 : 0);
      wr(0, 8'h72); rd(1, r); chk("R8 irq1 readback", r, dval(d,5));
    end

    // R5 out-of-range selector
    setreg(8'h07, 8'h0D);
    rd(1, r); chk("R5 selector readback", r, 8'h0D);
    setreg(8'h60, 8'h33);
    rd(1, r); chk("R5 bank read zero", r, 8'h00);
    check_devs("R5 no bank changed");

    // R3 exit keeps state
    wr(0, 8'hAA);
    chk("R3 closed", cfg_open, 0);
    chk("R3 pwrdn kept", pwrdn, 8'h79);
    check_devs("R3 outputs kept");
    rd(1, r); chk("R4 read after exit", r, 8'hFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule